// File: doc/BRIEF.md
# Snoop Result Combiner

This block gathers the per-cache snoop replies that follow each address phase on a snooping bus and reduces them to one collective answer. Each agent offers three indications: it holds the line, it holds the line dirty, and its reply is complete. The combined outputs say whether any agent shares the line and whether any holds it dirty. Dirty acts as an inhibit on memory. The combiner raises a one-cycle strobe once both combined values are safe to sample. With that strobe it says whether memory must supply the data, which is the case when no cache owns the line.

Each phase runs in one of two timing modes, chosen when the phase is accepted. In fixed-delay mode every agent's indications are sampled a set number of clocks after the address, and the done inputs play no part. In variable-delay mode memory must assume a cache may still supply the line, so the strobe waits until every agent has signalled done. A timeout bounds that wait, and a flag reports when the result was forced by the timeout. Only one phase is handled at a time, and an address phase offered while one is open is dropped.

Top module: `snoop_result_combiner`

## Requirements
- R1: When `snoop_valid` is high, `comb_shared` equals the OR of the shared indications that were captured for the phase. In fixed mode these are all agents at the capture clock. In variable mode they are the agents that reported.
- R2: When `snoop_valid` is high, `comb_inhibit` equals the OR of the captured dirty indications, under the same capture rule as R1.
- R3: In fixed mode the agents' inputs are sampled at the FIX_DLY-th rising edge after the edge that accepted the phase, and `snoop_valid` is high for the cycle that follows that edge. `snp_done` is ignored in this mode.
- R4: In variable mode, an agent's first `snp_done` seen after the accepting edge records that agent's shared and dirty values for the phase. Later done pulses or value changes from that agent are ignored. `snoop_valid` rises after the edge at which the last agent reports.
- R5: In variable mode, if some agent has still not reported at the TIMEOUT-th edge after acceptance, the result is strobed at that edge from the agents that did report, and `timed_out` is high together with `snoop_valid`. If the last agent reports exactly at that edge, `timed_out` stays low.
- R6: `mem_respond` is high exactly in the strobe cycles in which `comb_inhibit` is low.
- R7: `addr_phase` is accepted only while `busy` is low. `busy` rises after an accepting edge and falls after the strobe edge. A pulse on `addr_phase` while busy, including at the strobe edge, is dropped.
- R8: After reset, `snoop_valid`, `mem_respond`, `timed_out`, `busy`, `comb_shared` and `comb_inhibit` are all low.
- R9: `snoop_valid` lasts one cycle. `comb_shared` and `comb_inhibit` change only at a strobe and hold their values until the next strobe.
- R10: The timing mode comes from `var_mode` at the accepting edge (1 = variable, 0 = fixed). Changes to `var_mode` during an open phase have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_phase | input | 1 | Start of a bus address phase |
| var_mode | input | 1 | Mode for the phase being accepted: 1 variable, 0 fixed |
| snp_shared | input | NUM_AGENTS | Per-agent holds-a-copy indication |
| snp_dirty | input | NUM_AGENTS | Per-agent holds-dirty indication |
| snp_done | input | NUM_AGENTS | Per-agent reply-complete indication (variable mode) |
| comb_shared | output | 1 | OR of the captured shared indications |
| comb_inhibit | output | 1 | OR of the captured dirty indications; blocks memory |
| snoop_valid | output | 1 | One-cycle strobe: the combined values may be sampled |
| mem_respond | output | 1 | Memory must supply the data (strobe with no dirty holder) |
| timed_out | output | 1 | The strobe was forced by the variable-mode timeout |
| busy | output | 1 | A phase is open; new address phases are dropped |

## Verification
Time is counted in rising edges after the edge that accepts `addr_phase`. A fixed-mode result is due after edge FIX_DLY. A variable-mode result is due after the edge where the last agent's done is seen, or after edge TIMEOUT at the latest. `busy` follows one edge after acceptance or strobe. The bench drives each edge's inputs one nanosecond after the previous edge and samples all outputs at that same point. For every cycle of a phase it states whether the strobe is expected, so an early or late result fails in the cycle where it happens. After the strobe, one more cycle checks that the pulse has ended, that the combined values are held, and that `busy` is low.

// File: rtl/snoop_comb_pkg.sv
package snoop_comb_pkg;

  // Phase tracker state: idle, or an open phase in one of the two timing modes.
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIXED = 2'd1,
    PH_VAR   = 2'd2
  } phase_e;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/snoop_phase_timer.sv
module snoop_phase_timer
  import snoop_comb_pkg::*;
#(
  parameter int unsigned FIX_DLY = 3,
  parameter int unsigned TIMEOUT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic fix_hit,
  output logic tmo_hit
);

  localparam int unsigned MAXV = max_of(FIX_DLY, TIMEOUT);
  localparam int unsigned CW   = $clog2(MAXV + 1);
  localparam logic [CW-1:0] FIX_LAST = CW'(FIX_DLY - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(MAXV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // Edge k after the accepting edge sees cnt_q == k-1.
  always_comb begin
    cnt_en = start | run;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_d = '0;
    end else if (run && (cnt_q != CNT_TOP)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign fix_hit = run && (cnt_q == FIX_LAST);
  assign tmo_hit = run && (cnt_q == TMO_LAST);

  // The counter saturates and never wraps past its top value (R5 window).
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_TOP);

  // A fresh start always restarts the count at zero (R3 latency origin).
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));

endmodule

// File: rtl/snoop_reply_collect.sv
module snoop_reply_collect #(
  parameter int unsigned NUM_AGENTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  cap_all,
  input  logic                  watch,
  input  logic [NUM_AGENTS-1:0] done_i,
  input  logic [NUM_AGENTS-1:0] shared_i,
  input  logic [NUM_AGENTS-1:0] dirty_i,
  output logic                  sh_now,
  output logic                  dt_now,
  output logic                  all_now
);

  logic [NUM_AGENTS-1:0] rep_q, rep_d;
  logic [NUM_AGENTS-1:0] sh_q, sh_d;
  logic [NUM_AGENTS-1:0] dt_q, dt_d;
  logic [NUM_AGENTS-1:0] take;
  logic [NUM_AGENTS-1:0] fresh;

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
    logic en;

    always_comb begin
      fresh[g] = watch & done_i[g] & ~rep_q[g];
      take[g]  = cap_all | fresh[g];
      en       = clear | take[g];
      if (clear) begin
        rep_d[g] = 1'b0;
        sh_d[g]  = 1'b0;
        dt_d[g]  = 1'b0;
      end else begin
        rep_d[g] = rep_q[g] | fresh[g];
        sh_d[g]  = take[g] ? shared_i[g] : sh_q[g];
        dt_d[g]  = take[g] ? dirty_i[g]  : dt_q[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rep_q[g] <= 1'b0;
        sh_q[g]  <= 1'b0;
        dt_q[g]  <= 1'b0;
      end else if (en) begin
        rep_q[g] <= rep_d[g];
        sh_q[g]  <= sh_d[g];
        dt_q[g]  <= dt_d[g];
      end
    end
  end

  // Combined view including replies arriving this cycle.
  assign sh_now  = |sh_d;
  assign dt_now  = |dt_d;
  assign all_now = &rep_d;

  // Once an agent has reported, it stays reported until the next phase (R4).
  p_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((rep_q & $past(rep_q)) == $past(rep_q)));

  // A reported agent's captured values are frozen while watching (R4).
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !cap_all) |=> ((sh_q & $past(rep_q)) == ($past(sh_q) & $past(rep_q))));

endmodule

// File: rtl/snoop_result_combiner.sv
module snoop_result_combiner
  import snoop_comb_pkg::*;
#(
  parameter int unsigned NUM_AGENTS = 4,
  parameter int unsigned FIX_DLY    = 3,
  parameter int unsigned TIMEOUT    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_phase,
  input  logic                  var_mode,
  input  logic [NUM_AGENTS-1:0] snp_shared,
  input  logic [NUM_AGENTS-1:0] snp_dirty,
  input  logic [NUM_AGENTS-1:0] snp_done,
  output logic                  comb_shared,
  output logic                  comb_inhibit,
  output logic                  snoop_valid,
  output logic                  mem_respond,
  output logic                  timed_out,
  output logic                  busy
);

  phase_e state_q, state_d;
  logic   accept, open_ph, strobe, forced;
  logic   fix_hit, tmo_hit;
  logic   sh_now, dt_now, all_now;
  logic   valid_q, resp_q, tmo_q, sh_q, dt_q;
  logic   valid_d, resp_d, tmo_d;

  assign open_ph = (state_q != PH_IDLE);
  assign accept  = (state_q == PH_IDLE) & addr_phase;

  snoop_phase_timer #(
    .FIX_DLY (FIX_DLY),
    .TIMEOUT (TIMEOUT)
  ) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .run     (open_ph),
    .fix_hit (fix_hit),
    .tmo_hit (tmo_hit)
  );

  snoop_reply_collect #(
    .NUM_AGENTS (NUM_AGENTS)
  ) collect_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .cap_all  ((state_q == PH_FIXED) & fix_hit),
    .watch    (state_q == PH_VAR),
    .done_i   (snp_done),
    .shared_i (snp_shared),
    .dirty_i  (snp_dirty),
    .sh_now   (sh_now),
    .dt_now   (dt_now),
    .all_now  (all_now)
  );

  // Next-state and strobe decision.
  always_comb begin
    strobe  = 1'b0;
    forced  = 1'b0;
    state_d = state_q;
    unique case (state_q)
      PH_IDLE: begin
        if (addr_phase) state_d = var_mode ? PH_VAR : PH_FIXED;
      end
      PH_FIXED: begin
        strobe = fix_hit;
      end
      PH_VAR: begin
        strobe = all_now | tmo_hit;
        forced = tmo_hit & ~all_now;
      end
      default: state_d = PH_IDLE;
    endcase
    if (strobe) state_d = PH_IDLE;
    valid_d = strobe;
    resp_d  = strobe & ~dt_now;
    tmo_d   = forced;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      valid_q <= 1'b0;
      resp_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      resp_q  <= resp_d;
      tmo_q   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
      dt_q <= 1'b0;
    end else if (strobe) begin
      sh_q <= sh_now;
      dt_q <= dt_now;
    end
  end

  assign comb_shared  = sh_q;
  assign comb_inhibit = dt_q;
  assign snoop_valid  = valid_q;
  assign mem_respond  = resp_q;
  assign timed_out    = tmo_q;
  assign busy         = open_ph;

  // Memory only responds in a strobe cycle with no dirty holder (R6).
  p_resp_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_respond |-> (snoop_valid && !comb_inhibit));

  // A clean strobe always lets memory respond (R6).
  p_resp_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && !comb_inhibit) |-> mem_respond);

  // The strobe is a single-cycle pulse (R9).
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |=> !snoop_valid);

  // Combined values only move at a strobe (R9).
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_valid |-> ($stable(comb_shared) && $stable(comb_inhibit)));

  // Timeout flag only accompanies a strobe (R5).
  p_tmo_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timed_out |-> snoop_valid);

  // A phase opens only from an offered address phase (R7).
  p_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(addr_phase));

  // The strobe closes the open phase (R7).
  p_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid |-> (!busy && $past(busy)));

endmodule

// File: tb/snoop_result_combiner_tb_top.sv
module snoop_result_combiner_tb_top;

  localparam int N  = 4;
  localparam int FD = 3;
  localparam int TO = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         addr_phase, var_mode;
  logic [N-1:0] snp_shared, snp_dirty, snp_done;
  logic         comb_shared, comb_inhibit, snoop_valid, mem_respond, timed_out, busy;

  int n_tests = 0;
  int n_fail  = 0;
  int lat [N];

  always #2 clk = ~clk;

  snoop_result_combiner #(.NUM_AGENTS(N), .FIX_DLY(FD), .TIMEOUT(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .var_mode(var_mode),
    .snp_shared(snp_shared), .snp_dirty(snp_dirty), .snp_done(snp_done),
    .comb_shared(comb_shared), .comb_inhibit(comb_inhibit), .snoop_valid(snoop_valid),
    .mem_respond(mem_respond), .timed_out(timed_out), .busy(busy)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [N-1:0] rnd_vec();
    return N'($urandom);
  endfunction

  // Post-strobe cycle: pulse over, values held, phase closed.
  task automatic after_strobe(input logic es, input logic ed);
    addr_phase = 1'b0;
    snp_shared = rnd_vec();
    snp_dirty  = rnd_vec();
    snp_done   = rnd_vec();
    tick();
    chk("R9", "valid ends", snoop_valid, 0);
    chk("R9", "shared held", comb_shared, es);
    chk("R9", "inhibit held", comb_inhibit, ed);
    chk("R7", "busy low after strobe", busy, 0);
  endtask

  task automatic fixed_phase(input logic [N-1:0] sh, input logic [N-1:0] dt);
    addr_phase = 1'b1;
    var_mode   = 1'b0;
    snp_done   = rnd_vec();
    tick();
    chk("R7", "busy after accept", busy, 1);
    for (int k = 1; k <= FD; k++) begin
      addr_phase = 1'($urandom);
      var_mode   = 1'($urandom);   // R10: ignored mid-phase
      snp_done   = rnd_vec();      // R3: done ignored in fixed mode
      snp_shared = (k == FD) ? sh : rnd_vec();
      snp_dirty  = (k == FD) ? dt : rnd_vec();
      tick();
      if (k < FD) begin
        chk("R3", "no early strobe", snoop_valid, 0);
      end else begin
        chk("R3", "strobe at fixed delay", snoop_valid, 1);
        chk("R1", "shared OR", comb_shared, |sh);
        chk("R2", "inhibit OR", comb_inhibit, |dt);
        chk("R6", "memory respond", mem_respond, !(|dt));
        chk("R10", "no timeout in fixed mode", timed_out, 0);
      end
    end
    after_strobe(|sh, |dt);
  endtask

  task automatic var_phase(input logic [N-1:0] sh, input logic [N-1:0] dt);
    int mx = 0;
    int sk;
    logic tmo;
    logic es = 1'b0;
    logic ed = 1'b0;
    for (int i = 0; i < N; i++) if (lat[i] > mx) mx = lat[i];
    tmo = (mx > TO);
    sk  = tmo ? TO : mx;
    for (int i = 0; i < N; i++) begin
      if (lat[i] <= sk) begin
        es |= sh[i];
        ed |= dt[i];
      end
    end
    addr_phase = 1'b1;
    var_mode   = 1'b1;
    snp_done   = '1;                // done at accepting edge is not a report
    snp_shared = rnd_vec();
    snp_dirty  = rnd_vec();
    tick();
    chk("R7", "busy after accept", busy, 1);
    for (int k = 1; k <= sk; k++) begin
      addr_phase = 1'($urandom);
      var_mode   = 1'($urandom);
      for (int i = 0; i < N; i++) begin
        snp_done[i]   = (k >= lat[i]);
        snp_shared[i] = (k == lat[i]) ? sh[i] : 1'($urandom);
        snp_dirty[i]  = (k == lat[i]) ? dt[i] : 1'($urandom);
      end
      tick();
      if (k < sk) begin
        chk(tmo ? "R5" : "R4", "no strobe before last report", snoop_valid, 0);
      end else begin
        chk(tmo ? "R5" : "R4", "strobe due", snoop_valid, 1);
        chk("R5", "timeout flag", timed_out, tmo);
        chk("R1", "shared OR of reporters", comb_shared, es);
        chk("R2", "inhibit OR of reporters", comb_inhibit, ed);
        chk("R6", "memory respond", mem_respond, !ed);
      end
    end
    after_strobe(es, ed);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rst_n      = 1'b0;
    addr_phase = 1'b0;
    var_mode   = 1'b0;
    snp_shared = '0;
    snp_dirty  = '0;
    snp_done   = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8", "valid in reset", snoop_valid, 0);
    rst_n = 1'b1;
    tick();
    chk("R8", "valid", snoop_valid, 0);
    chk("R8", "respond", mem_respond, 0);
    chk("R8", "timeout", timed_out, 0);
    chk("R8", "busy", busy, 0);
    chk("R8", "shared", comb_shared, 0);
    chk("R8", "inhibit", comb_inhibit, 0);

    // Directed corners.
    fixed_phase('0, '0);
    fixed_phase('1, 4'b0100);
    for (int i = 0; i < N; i++) lat[i] = 1;
    var_phase(4'b0011, '0);
    lat[0] = TO; lat[1] = 2; lat[2] = 5; lat[3] = 1;     // last report on the timeout edge
    var_phase(4'b1001, 4'b0001);
    lat[0] = 2; lat[1] = TO + 1; lat[2] = 3; lat[3] = 4; // one agent silent
    var_phase(4'b0010, 4'b0010);
    for (int i = 0; i < N; i++) lat[i] = TO + 3;         // nobody reports
    var_phase('1, '1);

    // Random mix.
    for (int p = 0; p < 60; p++) begin
      if ($urandom_range(0, 1) == 0) begin
        fixed_phase(rnd_vec(), ($urandom_range(0, 2) == 0) ? rnd_vec() : '0);
      end else begin
        for (int i = 0; i < N; i++) lat[i] = $urandom_range(1, TO + 2);
        var_phase(rnd_vec(), ($urandom_range(0, 2) == 0) ? rnd_vec() : '0);
      end
      repeat ($urandom_range(0, 2)) begin
        addr_phase = 1'b0;
        tick();
        chk("R7", "idle without address", busy, 0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule